// File: doc/BRIEF.md
# UART Transmit and Receive FIFO Buffering

This block holds the byte queues that sit between a UART's shift registers and its host. It contains two independent queues. The transmit queue takes 8-bit words from the host and hands them to the serializer. The receive queue takes 12-bit words from the deserializer: 8 data bits and 4 error flags. Each side uses a plain push/pop handshake. The word at the head of each queue is shown on its read-data port before it is popped.

A mode input selects the depth of both queues. When it is low, each queue is a single-entry holding register. When it is high, each queue holds 16 entries. A small state machine with the states MODE_HOLD and MODE_QUEUE follows this input. The ENABLE transition (MODE_HOLD to MODE_QUEUE) and the DISABLE transition (MODE_QUEUE to MODE_HOLD) each empty both queues. Each direction has its own fill-level select that raises an interrupt request. The block also reports empty and full for both directions, and a sticky receive overrun flag that is cleared by a strobe.

Top module: `uart_fifo_buf`

## Requirements
- R1: After reset, both queues are empty and not full, overrun is 0, rx_irq is 0 and tx_irq is 1. The state is MODE_HOLD, and both level selects are treated as the half mark by the stimulus that follows.
- R2: With fifo_en high (MODE_QUEUE), each queue accepts 16 entries. Full asserts only at 16 entries. Words leave in the order they arrived.
- R3: With fifo_en low (MODE_HOLD), each queue holds exactly one entry, and full asserts after a single push.
- R4: A push into a full transmit queue is dropped and the stored words are unchanged. A pop from an empty queue has no effect on later data.
- R5: A receive push while the receive queue is full sets rx_overrun. The incoming word is dropped and the stored words stay intact.
- R6: rx_overrun stays set until an ovr_clr strobe. If a new overrun arrives in the same cycle as the strobe, the flag stays set.
- R7: Level select codes map to these fractions of 16: 0 gives 2 entries, 1 gives 4, 2 gives 8, 3 gives 12 and 4 gives 14. Codes 5 to 7 behave as code 2.
- R8: In MODE_QUEUE, rx_irq is high when the receive occupancy is at or above the threshold. tx_irq is high when the transmit occupancy is at or below the threshold.
- R9: In MODE_HOLD, rx_irq is high when the receive register holds a word, and tx_irq is high when the transmit register is empty. These hold for every level code.
- R10: Any change of fifo_en empties both queues at the next clock edge. A push presented in that same cycle is discarded.
- R11: Receive entries keep all 12 bits and transmit entries keep all 8 bits. The head word is visible on the read-data port before it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects 16-entry queues, 0 selects holding registers |
| tx_lvl_sel | input | 3 | Transmit trigger level code |
| rx_lvl_sel | input | 3 | Receive trigger level code |
| tx_push | input | 1 | Host writes a transmit word |
| tx_wdata | input | 8 | Transmit word |
| tx_pop | input | 1 | Serializer takes the head transmit word |
| tx_rdata | output | 8 | Head of the transmit queue |
| rx_push | input | 1 | Deserializer delivers a received word |
| rx_wdata | input | 12 | Received word: data and error flags |
| rx_pop | input | 1 | Host reads the head receive word |
| rx_rdata | output | 12 | Head of the receive queue |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_irq | output | 1 | Transmit level request |
| rx_irq | output | 1 | Receive level request |

## Verification
The assertions assume that fifo_en and both level selects change only at clock edges. They also assume that a push or pop is a one-cycle strobe that is sampled together with its data. The properties about held counts assume that no flush occurs in the cycle they cover. The bench drives every input on the falling edge and lifts each strobe after one cycle. It changes fifo_en only between scenarios. It reads the flags on the falling edge that follows the rising edge that registered each request.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int LVL_W = 3;

    typedef enum logic [0:0] {
        MODE_HOLD  = 1'b0,
        MODE_QUEUE = 1'b1
    } fifo_mode_e;

    // Trigger fraction in eighths of the queue depth
    function automatic int lvl_eighths(input logic [LVL_W-1:0] sel);
        int e;
        case (sel)
            3'd0:    e = 1;
            3'd1:    e = 2;
            3'd2:    e = 4;
            3'd3:    e = 6;
            3'd4:    e = 7;
            default: e = 4;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/uart_fifo_store.sv
module uart_fifo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rd_ptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [CW-1:0] lim);
        return (CW'(p) + CW'(1) >= lim) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr, cap);
            if (do_pop)  rd_ptr <= step(rd_ptr, cap);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);
    a_r4_full_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));
    a_r4_empty_pop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/uart_fifo_trigger.sv
module uart_fifo_trigger
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             queue_mode,
    input  logic [LVL_W-1:0] sel,
    input  logic [CW-1:0]    count,
    input  logic [CW-1:0]    cap,
    output logic             irq
);
    int prod;
    int thr;

    always_comb begin
        prod = DEPTH * lvl_eighths(sel);
        if (queue_mode) thr = IS_RX ? (prod + 7) / 8 : prod / 8;
        else            thr = IS_RX ? 1 : 0;
        irq = IS_RX ? (int'(count) >= thr) : (int'(count) <= thr);
    end

    generate
        if (IS_RX) begin : g_rx_chk
            a_r9_rx_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
                irq |-> (count != '0));
        end else begin : g_tx_chk
            a_r8_tx_irq_not_full: assert property (@(posedge clk) disable iff (!rst_n)
                irq |-> (count < cap));
        end
    endgenerate

endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TX_W  = 8,
    parameter int RX_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] tx_lvl_sel,
    input  logic [LVL_W-1:0] rx_lvl_sel,
    input  logic             tx_push,
    input  logic [TX_W-1:0]  tx_wdata,
    input  logic             tx_pop,
    output logic [TX_W-1:0]  tx_rdata,
    input  logic             rx_push,
    input  logic [RX_W-1:0]  rx_wdata,
    input  logic             rx_pop,
    output logic [RX_W-1:0]  rx_rdata,
    input  logic             ovr_clr,
    output logic             tx_empty,
    output logic             tx_full,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_overrun,
    output logic             tx_irq,
    output logic             rx_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    fifo_mode_e    state_q, state_d;
    logic          flush;
    logic [CW-1:0] cap;
    logic          queue_mode;
    logic [CW-1:0] tx_count, rx_count;
    logic          ovr_set;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_HOLD;
        else        state_q <= state_d;
    end

    // Transitions: ENABLE and DISABLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HOLD:  if (fifo_en)  state_d = MODE_QUEUE;
            MODE_QUEUE: if (!fifo_en) state_d = MODE_HOLD;
            default:    state_d = MODE_HOLD;
        endcase
    end

    // Per-state outputs
    always_comb begin
        cap        = CW'(1);
        flush      = 1'b0;
        queue_mode = 1'b0;
        unique case (state_q)
            MODE_HOLD: begin
                cap   = CW'(1);
                flush = fifo_en;
            end
            MODE_QUEUE: begin
                cap        = CW'(DEPTH);
                flush      = !fifo_en;
                queue_mode = 1'b1;
            end
            default: ;
        endcase
    end

    uart_fifo_store #(.W(TX_W), .DEPTH(DEPTH), .CW(CW)) u_tx_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_fifo_store #(.W(RX_W), .DEPTH(DEPTH), .CW(CW)) u_rx_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    uart_fifo_trigger #(.DEPTH(DEPTH), .IS_RX(1'b0), .CW(CW)) u_tx_trig (
        .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode), .sel(tx_lvl_sel),
        .count(tx_count), .cap(cap), .irq(tx_irq)
    );

    uart_fifo_trigger #(.DEPTH(DEPTH), .IS_RX(1'b1), .CW(CW)) u_rx_trig (
        .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode), .sel(rx_lvl_sel),
        .count(rx_count), .cap(cap), .irq(rx_irq)
    );

    // Sticky overrun: a new event wins over the clear strobe
    assign ovr_set = rx_push && rx_full && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_overrun <= 1'b0;
        else if (ovr_set) rx_overrun <= 1'b1;
        else if (ovr_clr) rx_overrun <= 1'b0;
    end

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !flush) |=> rx_overrun);
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);
    a_r6_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !(rx_push && rx_full)) |=> !rx_overrun);
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_empty && tx_empty));
    a_r3_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HOLD && !flush && !rx_empty) |-> rx_full);

endmodule

// File: tb/uart_fifo_buf_bench.sv
module uart_fifo_buf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic [2:0]  tx_lvl_sel = 3'd2, rx_lvl_sel = 3'd2;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [7:0]  tx_wdata = '0, tx_rdata;
    logic [11:0] rx_wdata = '0, rx_rdata;
    logic        tx_empty, tx_full, rx_empty, rx_full, rx_overrun, tx_irq, rx_irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    uart_fifo_buf u_uart_fifo_buf (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .tx_lvl_sel(tx_lvl_sel), .rx_lvl_sel(rx_lvl_sel),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .ovr_clr(ovr_clr), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_thr(input int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 12;
            4: return 14;
            default: return 8;
        endcase
    endfunction

    // All helpers start and end at a falling edge
    task automatic rx_put(input logic [11:0] d);
        rx_push = 1'b1; rx_wdata = d;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic rx_take();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic tx_put(input logic [7:0] d);
        tx_push = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic tx_take();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 overrun", rx_overrun, 0);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 tx_irq", tx_irq, 1);
    endtask

    task automatic t_hold();
        rx_lvl_sel = 3'd4; tx_lvl_sel = 3'd0;
        rx_put(12'hA5C);
        chk("R3 rx_full after one", rx_full, 1);
        chk("R9 rx_irq with word", rx_irq, 1);
        chk("R11 rx head 12 bits", rx_rdata, 12'hA5C);
        rx_put(12'h123);
        chk("R5 overrun in hold", rx_overrun, 1);
        chk("R5 hold word kept", rx_rdata, 12'hA5C);
        rx_take();
        chk("R3 rx empty after pop", rx_empty, 1);
        chk("R6 overrun sticky", rx_overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R6 overrun cleared", rx_overrun, 0);
        tx_put(8'hE7);
        chk("R3 tx_full after one", tx_full, 1);
        chk("R9 tx_irq off when held", tx_irq, 0);
        chk("R11 tx head", tx_rdata, 8'hE7);
        tx_take();
        chk("R9 tx_irq on when empty", tx_irq, 1);
    endtask

    task automatic t_enable_flush();
        rx_put(12'h0F0);
        tx_put(8'h3C);
        fifo_en = 1'b1;
        rx_push = 1'b1; rx_wdata = 12'h777;
        @(negedge clk);
        rx_push = 1'b0;
        chk("R10 rx flushed on enable", rx_empty, 1);
        chk("R10 tx flushed on enable", tx_empty, 1);
    endtask

    task automatic t_tx_depth();
        for (int i = 0; i < 16; i++) begin
            tx_put(8'(i * 13 + 1));
            if (i == 14) chk("R2 tx not full at 15", tx_full, 0);
        end
        chk("R2 tx full at 16", tx_full, 1);
        tx_put(8'hFF);
        chk("R4 tx still full", tx_full, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R2 tx order", tx_rdata, (i * 13 + 1) & 8'hFF);
            tx_take();
        end
        chk("R4 tx empty after drain", tx_empty, 1);
        tx_take();
        tx_put(8'h5A);
        chk("R4 pop on empty ignored", tx_rdata, 8'h5A);
        chk("R4 one entry after", tx_empty, 0);
        tx_take();
    endtask

    task automatic t_rx_levels();
        for (int code = 0; code < 8; code++) begin
            rx_lvl_sel = 3'(code);
            for (int n = 1; n <= 16; n++) begin
                rx_put(12'(n));
                chk($sformatf("R7 R8 rx level code %0d n %0d", code, n),
                    rx_irq, (n >= exp_thr(code)) ? 1 : 0);
            end
            for (int n = 0; n < 16; n++) rx_take();
        end
    endtask

    task automatic t_tx_levels();
        for (int code = 0; code < 8; code++) begin
            tx_lvl_sel = 3'(code);
            chk("R8 tx irq empty", tx_irq, 1);
            for (int n = 1; n <= 16; n++) begin
                tx_put(8'(n));
                chk($sformatf("R7 R8 tx level code %0d n %0d", code, n),
                    tx_irq, (n <= exp_thr(code)) ? 1 : 0);
            end
            for (int n = 0; n < 16; n++) tx_take();
        end
    endtask

    task automatic t_rx_overrun_full();
        for (int i = 0; i < 16; i++) rx_put(12'(12'h800 + i * 37));
        chk("R2 rx full at 16", rx_full, 1);
        chk("R5 no overrun yet", rx_overrun, 0);
        rx_put(12'hBAD);
        chk("R5 overrun set", rx_overrun, 1);
        rx_push = 1'b1; rx_wdata = 12'hBEE; ovr_clr = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; ovr_clr = 1'b0;
        chk("R6 set wins over clear", rx_overrun, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R5 R11 rx contents intact", rx_rdata, (12'h800 + i * 37) & 12'hFFF);
            rx_take();
        end
        chk("R5 rx empty after drain", rx_empty, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R6 clear", rx_overrun, 0);
    endtask

    task automatic t_disable_flush();
        rx_put(12'h111);
        rx_put(12'h222);
        tx_put(8'h33);
        fifo_en = 1'b0;
        @(negedge clk);
        chk("R10 rx flushed on disable", rx_empty, 1);
        chk("R10 tx flushed on disable", tx_empty, 1);
        rx_lvl_sel = 3'd0;
        rx_put(12'h444);
        chk("R3 back to single entry", rx_full, 1);
        chk("R9 hold rx_irq", rx_irq, 1);
        rx_take();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_enable_flush();
        t_tx_depth();
        t_rx_levels();
        t_tx_levels();
        t_rx_overrun_full();
        t_disable_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule